// File: doc/BRIEF.md
# Bus Request Rule Checker

This block watches the request channel of a 32-bit TL-UL device port and decides, for every valid request beat, whether the request obeys the bus rules. It looks at the opcode, the low address bits, the transfer size and the byte mask. It raises a single error bit when any rule is broken. The device's response logic uses that bit to set the error flag on the matching response beat and to suppress any state change for a failing write.

The checks work lane by lane. The size and the low address bits select a window of byte lanes. The mask is then compared against that window. A bit set outside the window is an error. For a full-word write, a lane inside the window that is left clear is also an error. Reads get the same window check as writes. Address bits above the lane offset are not inspected.

The error can be presented combinationally, in the same cycle as the request, or from a register one cycle later. A parameter picks between the two. In both cases the bit is forced low when no request is presented.

Top module: `req_rule_chk`

## Requirements
- R1: The only legal opcodes are 3'd0 (full-word write), 3'd1 (partial write) and 3'd4 (read). A valid request carrying any other opcode value raises the error.
- R2: For opcode 3'd0, every lane inside the window must have its mask bit set. A clear bit inside the window raises the error, for example size 2 at offset 0 with mask 4'b0111.
- R3: A mask bit set on a lane outside the window raises the error. Examples are offset 0, size 0, mask 4'b0010, and offset 1, size 0, mask 4'b0001.
- R4: The address must be a multiple of 2^size. Offset 1 with size 1 or size 2, and offset 2 with size 2, raise the error.
- R5: A size value above 2 (size 3) raises the error for every opcode, offset and mask.
- R6: The lane window is defined as follows. Size 2 covers lanes 0 to 3. Size 1 covers lanes 2*a[1] and 2*a[1]+1. Size 0 covers lane a[1:0]. A legal, aligned request whose mask stays inside its window raises no error. A partial write may leave window lanes clear, including an all-zero mask. Address bits 31:2 have no effect.
- R7: Reads get the same window check as writes. A read with a stray mask bit raises the error. A read whose mask covers only part of its window does not.
- R8: While a_valid is low, the error output is 0, whatever the other inputs carry.
- R9: With REG_OUT=1 (the default), the error appears on the clock edge after the request cycle, and reset clears it to 0. With REG_OUT=0, the error follows the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_valid_i | input | 1 | A request beat is present |
| a_opcode_i | input | 3 | Request opcode |
| a_address_i | input | AW (32) | Request byte address |
| a_size_i | input | SIZE_W (2) | log2 of the transfer size in bytes |
| a_mask_i | input | DATA_W/8 (4) | Byte-lane enables |
| err_o | output | 1 | Request breaks a bus rule |

## Verification
The block's only state is the output register. If that register held a wrong value, err_o would show a stale or missing error for exactly one beat, on the edge after the offending request. The bench therefore checks the registered copy at every step, in step with the combinational copy, and checks back-to-back good and bad requests separately. A wrong window or alignment derivation in the combinational logic is visible in the same cycle, but only for particular lane patterns. For that reason every opcode, size, offset and mask combination is swept against an independent model.

// File: rtl/req_rule_pkg.sv
package req_rule_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        OPC_WR_FULL = 3'd0,
        OPC_WR_PART = 3'd1,
        OPC_RD      = 3'd4
    } opc_e;

    // bit positions of the individual rule violations
    localparam int unsigned VI_OPC   = 0;
    localparam int unsigned VI_SIZE  = 1;
    localparam int unsigned VI_ALIGN = 2;
    localparam int unsigned VI_STRAY = 3;
    localparam int unsigned VI_HOLE  = 4;
    localparam int unsigned VIOL_N   = 5;

    typedef struct packed {
        logic err;
    } chk_state_t;
endpackage

// File: rtl/lane_window.sv
module lane_window #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned SIZE_W = 2
) (
    input  logic [SIZE_W-1:0] size_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [LANES-1:0]  win_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(OFF_W);

    logic size_ok;
    assign size_ok = (size_i <= MAX_SZ);

    // a lane is in the window when it shares the offset's aligned block
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign win_o[i] = size_ok && ((OFF_W'(i) >> size_i) == (off_i >> size_i));
    end
endmodule

// File: rtl/rule_eval.sv
module rule_eval
    import req_rule_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned SIZE_W = 2
) (
    input  logic [2:0]        opcode_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [LANES-1:0]  win_i,
    output logic [VIOL_N-1:0] viol_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(OFF_W);

    // offset bits that must be zero for the given size
    logic [OFF_W-1:0] low_m;
    for (genvar b = 0; b < OFF_W; b++) begin : g_low
        assign low_m[b] = (SIZE_W'(b) < size_i);
    end

    always_comb begin
        viol_o           = '0;
        viol_o[VI_OPC]   = !(opcode_i inside {OPC_WR_FULL, OPC_WR_PART, OPC_RD});
        viol_o[VI_SIZE]  = (size_i > MAX_SZ);
        viol_o[VI_ALIGN] = ((off_i & low_m) != '0);
        viol_o[VI_STRAY] = |(mask_i & ~win_i);
        viol_o[VI_HOLE]  = (opcode_i == OPC_WR_FULL) && ((mask_i & win_i) != win_i);
    end
endmodule

// File: rtl/req_rule_chk.sv
module req_rule_chk
    import req_rule_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned AW      = 32,
    parameter int unsigned SIZE_W  = 2,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  a_valid_i,
    input  logic [2:0]            a_opcode_i,
    input  logic [AW-1:0]         a_address_i,
    input  logic [SIZE_W-1:0]     a_size_i,
    input  logic [DATA_W/8-1:0]   a_mask_i,
    output logic                  err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    logic [OFF_W-1:0]  off;
    logic [LANES-1:0]  win;
    logic [VIOL_N-1:0] viol;
    logic              unused_addr_hi;
    chk_state_t        st_d, st_q;

    assign off            = a_address_i[OFF_W-1:0];
    assign unused_addr_hi = ^a_address_i[AW-1:OFF_W];

    lane_window #(
        .LANES (LANES),
        .OFF_W (OFF_W),
        .SIZE_W(SIZE_W)
    ) u_win (
        .size_i(a_size_i),
        .off_i (off),
        .win_o (win)
    );

    rule_eval #(
        .LANES (LANES),
        .OFF_W (OFF_W),
        .SIZE_W(SIZE_W)
    ) u_rules (
        .opcode_i(a_opcode_i),
        .size_i  (a_size_i),
        .off_i   (off),
        .mask_i  (a_mask_i),
        .win_i   (win),
        .viol_o  (viol)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = a_valid_i && (|viol);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    if (REG_OUT) begin : g_reg
        assign err_o = st_q.err;
    end else begin : g_comb
        assign err_o = st_d.err;
    end
endmodule

// File: rtl/req_rule_chk_sva.sv
module req_rule_chk_sva #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned AW      = 32,
    parameter int unsigned SIZE_W  = 2,
    parameter bit          REG_OUT = 1'b1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                a_valid_i,
    input logic [2:0]          a_opcode_i,
    input logic [AW-1:0]       a_address_i,
    input logic [SIZE_W-1:0]   a_size_i,
    input logic [DATA_W/8-1:0] a_mask_i,
    input logic                err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);
    localparam logic [SIZE_W-1:0] MAXS = SIZE_W'(OFF_W);

    logic [OFF_W-1:0] off;
    logic             unused_hi;
    logic [6:0]       fl, fl_q, obs;

    assign off       = a_address_i[OFF_W-1:0];
    assign unused_hi = ^a_address_i[AW-1:OFF_W];

    always_comb begin
        fl[0] = a_valid_i && !(a_opcode_i == 3'd0 || a_opcode_i == 3'd1 || a_opcode_i == 3'd4);
        fl[1] = a_valid_i && (a_size_i > MAXS);
        fl[2] = a_valid_i && a_opcode_i == 3'd0 && a_size_i == MAXS && off == '0
                && a_mask_i != '1;
        fl[3] = a_valid_i && a_size_i == '0 && ((a_mask_i & ~(LANES'(1) << off)) != '0);
        fl[4] = a_valid_i && a_size_i == SIZE_W'(1) && off[0];
        fl[5] = !a_valid_i;
        fl[6] = a_valid_i && a_opcode_i == 3'd4 && a_size_i == MAXS && off == '0
                && a_mask_i == '1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= 7'b0100000;
        else         fl_q <= fl;
    end

    assign obs = REG_OUT ? fl_q : fl;

    a_r1_bad_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni) obs[0] |-> err_o);
    a_r5_size_over:  assert property (@(posedge clk_i) disable iff (!rst_ni) obs[1] |-> err_o);
    a_r2_full_hole:  assert property (@(posedge clk_i) disable iff (!rst_ni) obs[2] |-> err_o);
    a_r3_stray_lane: assert property (@(posedge clk_i) disable iff (!rst_ni) obs[3] |-> err_o);
    a_r4_misalign:   assert property (@(posedge clk_i) disable iff (!rst_ni) obs[4] |-> err_o);
    a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni) obs[5] |-> !err_o);
    a_r6_clean_read: assert property (@(posedge clk_i) disable iff (!rst_ni) obs[6] |-> !err_o);
endmodule

bind req_rule_chk req_rule_chk_sva #(
    .DATA_W (DATA_W),
    .AW     (AW),
    .SIZE_W (SIZE_W),
    .REG_OUT(REG_OUT)
) u_sva (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_valid_i  (a_valid_i),
    .a_opcode_i (a_opcode_i),
    .a_address_i(a_address_i),
    .a_size_i   (a_size_i),
    .a_mask_i   (a_mask_i),
    .err_o      (err_o)
);

// File: tb/sim_req_rule_chk.sv
module sim_req_rule_chk;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic [2:0]  op = 3'd4;
    logic [31:0] adr = '0;
    logic [1:0]  sz = 2'd2;
    logic [3:0]  msk = 4'hF;
    logic        err_r, err_c;
    int          n_vec = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    req_rule_chk u0 (
        .clk_i(clk), .rst_ni(rst_n), .a_valid_i(vld), .a_opcode_i(op),
        .a_address_i(adr), .a_size_i(sz), .a_mask_i(msk), .err_o(err_r)
    );

    req_rule_chk #(.REG_OUT(1'b0)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .a_valid_i(vld), .a_opcode_i(op),
        .a_address_i(adr), .a_size_i(sz), .a_mask_i(msk), .err_o(err_c)
    );

    task automatic cmp(string tag, logic got, logic exp, string what);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b (op=%0d adr=%h sz=%0d msk=%b vld=%0b)",
                     tag, what, got, exp, op, adr, sz, msk, vld);
        end
    endtask

    // drive one beat, check both variants at their own latency
    task automatic apply(string tag, logic v, logic [2:0] o, logic [31:0] a,
                         logic [1:0] s, logic [3:0] m, logic exp);
        @(negedge clk);
        vld = v; op = o; adr = a; sz = s; msk = m;
        #1 cmp(tag, err_c, exp, "same-cycle");
        @(negedge clk);
        cmp(tag, err_r, exp, "registered");
    endtask

    // independent model written from the requirements
    function automatic logic model(logic v, logic [2:0] o, logic [1:0] a,
                                   logic [1:0] s, logic [3:0] m);
        int unsigned n;
        logic [3:0]  w;
        if (!v) return 1'b0;
        if (!(o == 3'd0 || o == 3'd1 || o == 3'd4)) return 1'b1;
        if (s > 2'd2) return 1'b1;
        n = 1 << s;
        if ((int'(a) % n) != 0) return 1'b1;
        w = 4'(((1 << n) - 1) << a);
        if ((m & ~w) != 4'h0) return 1'b1;
        if (o == 3'd0 && m != w) return 1'b1;
        return 1'b0;
    endfunction

    task automatic t_reset();
        vld = 1'b1; op = 3'd7; adr = '0; sz = 2'd2; msk = 4'hF;
        repeat (3) @(negedge clk);
        cmp("R9", err_r, 1'b0, "register cleared in reset");
        cmp("R1", err_c, 1'b1, "bad opcode during reset, same-cycle");
        rst_n = 1'b1;
    endtask

    task automatic t_opcode();
        apply("R1", 1'b1, 3'd2, 32'h0, 2'd2, 4'hF, 1'b1);
        apply("R1", 1'b1, 3'd3, 32'h0, 2'd2, 4'hF, 1'b1);
        apply("R1", 1'b1, 3'd5, 32'h0, 2'd2, 4'hF, 1'b1);
        apply("R1", 1'b1, 3'd1, 32'h0, 2'd2, 4'hF, 1'b0);
    endtask

    task automatic t_full();
        apply("R2", 1'b1, 3'd0, 32'h0, 2'd2, 4'b0111, 1'b1);
        apply("R2", 1'b1, 3'd0, 32'h2, 2'd1, 4'b0100, 1'b1);
        apply("R2", 1'b1, 3'd0, 32'h3, 2'd0, 4'b0000, 1'b1);
        apply("R2", 1'b1, 3'd0, 32'h2, 2'd1, 4'b1100, 1'b0);
    endtask

    task automatic t_stray();
        apply("R3", 1'b1, 3'd1, 32'h0, 2'd0, 4'b0010, 1'b1);
        apply("R3", 1'b1, 3'd1, 32'h1, 2'd0, 4'b0001, 1'b1);
        apply("R3", 1'b1, 3'd1, 32'h0, 2'd1, 4'b0100, 1'b1);
    endtask

    task automatic t_align();
        apply("R4", 1'b1, 3'd4, 32'h1, 2'd1, 4'b0010, 1'b1);
        apply("R4", 1'b1, 3'd4, 32'h2, 2'd2, 4'b1100, 1'b1);
        apply("R4", 1'b1, 3'd0, 32'h1, 2'd2, 4'hF, 1'b1);
    endtask

    task automatic t_size();
        apply("R5", 1'b1, 3'd4, 32'h0, 2'd3, 4'hF, 1'b1);
        apply("R5", 1'b1, 3'd1, 32'h0, 2'd3, 4'h0, 1'b1);
    endtask

    task automatic t_legal();
        apply("R6", 1'b1, 3'd1, 32'h0, 2'd2, 4'b0000, 1'b0);
        apply("R6", 1'b1, 3'd1, 32'h3, 2'd0, 4'b1000, 1'b0);
        apply("R6", 1'b1, 3'd0, 32'hFFFF_FFFC, 2'd2, 4'hF, 1'b0);
        apply("R6", 1'b1, 3'd1, 32'h8000_0002, 2'd1, 4'b1000, 1'b0);
    endtask

    task automatic t_read();
        apply("R7", 1'b1, 3'd4, 32'h2, 2'd0, 4'b1100, 1'b1);
        apply("R7", 1'b1, 3'd4, 32'h0, 2'd2, 4'b0011, 1'b0);
        apply("R7", 1'b1, 3'd4, 32'h2, 2'd1, 4'b0100, 1'b0);
    endtask

    task automatic t_idle();
        apply("R8", 1'b0, 3'd7, 32'h1, 2'd3, 4'hF, 1'b0);
        apply("R8", 1'b0, 3'd0, 32'h0, 2'd0, 4'b1110, 1'b0);
    endtask

    task automatic t_latency();
        apply("R9", 1'b1, 3'd4, 32'h0, 2'd2, 4'hF, 1'b0);
        @(negedge clk);
        op = 3'd6;
        #1;
        cmp("R9", err_c, 1'b1, "same-cycle on bad beat");
        cmp("R9", err_r, 1'b0, "registered still shows prior beat");
        @(negedge clk);
        cmp("R9", err_r, 1'b1, "registered one edge later");
        op = 3'd4;
        #1;
        cmp("R9", err_c, 1'b0, "same-cycle recovers");
        cmp("R9", err_r, 1'b1, "registered holds until edge");
        @(negedge clk);
        cmp("R9", err_r, 1'b0, "registered recovers");
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 4; a++)
                    for (int m = 0; m < 16; m++)
                        apply("R1/R2/R3/R4/R5/R7 sweep", 1'b1, 3'(o),
                              32'h5A00_0000 | (32'(m) << 12) | 32'(a), 2'(s), 4'(m),
                              model(1'b1, 3'(o), 2'(a), 2'(s), 4'(m)));
    endtask

    initial begin
        t_reset();
        t_opcode();
        t_full();
        t_stray();
        t_align();
        t_size();
        t_legal();
        t_read();
        t_idle();
        t_latency();
        t_sweep();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got no finish, expected finish before timeout");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule